// File: doc/BRIEF.md
# Shared-Memory Mailbox Message Sender

This block posts one outgoing message into a mailbox region held in shared memory. A client starts a transfer by presenting a byte length with `req_valid`, then streams the payload as 32-bit words over a valid/ready channel. The block stores each word after a one-word header, then writes the byte length into that header last, so the remote side never sees a half-written message. It reads the header back, and only when the stored value matches does it pulse a doorbell towards the remote processor. It then polls the header at a fixed spacing until the remote zeroes it, which means the message was consumed. If the remote stays silent for the full poll budget, the block zeroes the header itself and reports a timeout.

The mailbox base offset and its size in bytes come from link bring-up and are inputs. A send made while the link is down, or with a length that does not fit the mailbox, is refused at once without touching memory. `busy` stays high from acceptance until the single-cycle `done` pulse that carries the result code.

States: `S_IDLE` waits for a request. It goes to `S_DONE` when the request is refused, to `S_COMMIT` for an empty message, and to `S_FILL` otherwise. `S_FILL` writes payload words and moves to `S_COMMIT` after the last one. `S_COMMIT` writes the header and moves to `S_VERIFY`. `S_VERIFY` goes to `S_RING` on a match and to `S_DONE` on a mismatch. `S_RING` moves to `S_GAP`, and `S_GAP` moves to `S_POLL` once the spacing has elapsed. `S_POLL` goes to `S_DONE` on a zero header, to `S_CLEAR` on the last attempt, and back to `S_GAP` otherwise. `S_CLEAR` moves to `S_DONE`, and `S_DONE` returns to `S_IDLE`.

Top module: `mbox_sender`

## Requirements
- R1: After reset, `busy`, `done`, `doorbell`, `wd_ready`, `mem_we` and `mem_re` are all low.
- R2: A request made while `link_up` is low ends with `done` and status 2 (no link). No memory write and no doorbell take place.
- R3: A request is refused with status 1 (bad length) unless `req_len` is a multiple of 4 and `req_len + 4 <= mbox_size`. A refused request causes no memory write and no doorbell.
- R4: Payload word k (0-based, in stream order) is written as a full 32-bit value to byte address `mbox_base + 4 + 4*k`. Each word is taken only on a cycle where both `wd_valid` and `wd_ready` are high.
- R5: The header at `mbox_base` is written with the byte length only after every payload word has been written.
- R6: After the commit, the header is read once. If it equals the length, `doorbell` pulses high for exactly one cycle, once per message.
- R7: If the read-back differs from the length, the result is status 4 (read-back error) and no doorbell is raised.
- R8: After the doorbell the header is read at most `POLL_MAX` times, with `POLL_GAP` idle cycles before each read. A zero read ends the send with status 0 (ok).
- R9: If no poll reads zero, the block writes 0 to the header and ends with status 3 (timeout).
- R10: `busy` is high from acceptance until the `done` pulse, which lasts one cycle. `req_valid` while busy is ignored.
- R11: A header that reads zero on the last permitted poll counts as success, not timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| link_up | input | 1 | Link open to the remote side |
| mbox_base | input | AW | Byte offset of the mailbox header |
| mbox_size | input | AW | Mailbox size in bytes |
| req_valid | input | 1 | Start a send (taken when idle) |
| req_len | input | AW | Message length in bytes |
| busy | output | 1 | Send in progress |
| wd_valid | input | 1 | Payload word valid |
| wd_ready | output | 1 | Payload word accepted |
| wd_data | input | 32 | Payload word |
| mem_we | output | 1 | Shared-memory write strobe |
| mem_re | output | 1 | Shared-memory read strobe |
| mem_addr | output | AW | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, combinational for `mem_addr` |
| doorbell | output | 1 | One-cycle notification to the remote |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | Result code, valid with `done` |

## Verification
Two events can fall in the same cycle: the remote zeroing the header, and the block's final poll, which decides between success and timeout. The bench provokes this by having the remote clear the header a chosen number of cycles after the doorbell. It sweeps that delay across the window around the last poll. For each delay it computes from the poll spacing and budget whether the zero is visible by the final read, and it checks the status as ok or timeout accordingly, along with the header contents and the number of polls.

// File: rtl/mbs_pkg.sv
package mbs_pkg;
    localparam int DW = 32;

    typedef enum logic [2:0] {
        ST_OK      = 3'd0,
        ST_BADLEN  = 3'd1,
        ST_NOLINK  = 3'd2,
        ST_TIMEOUT = 3'd3,
        ST_RBERR   = 3'd4
    } send_status_e;

    typedef enum logic [3:0] {
        S_IDLE, S_FILL, S_COMMIT, S_VERIFY, S_RING,
        S_GAP, S_POLL, S_CLEAR, S_DONE
    } send_state_e;
endpackage

// File: rtl/mbs_req_check.sv
module mbs_req_check
    import mbs_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          link_up,
    input  logic [AW-1:0] len,
    input  logic [AW-1:0] size,
    output logic          accept,
    output send_status_e  verdict
);
    localparam int XW = AW + 1;

    logic [XW-1:0] need;
    logic          fits;
    logic          aligned;

    always_comb begin
        need    = {1'b0, len} + XW'(4);
        fits    = need <= {1'b0, size};
        aligned = (len[1:0] == 2'b00);
        if (!link_up) begin
            accept  = 1'b0;
            verdict = ST_NOLINK;
        end else if (!(fits && aligned)) begin
            accept  = 1'b0;
            verdict = ST_BADLEN;
        end else begin
            accept  = 1'b1;
            verdict = ST_OK;
        end
    end
endmodule

// File: rtl/mbs_poll_timer.sv
module mbs_poll_timer #(
    parameter int POLL_GAP = 4,
    parameter int POLL_MAX = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic wait_en,
    input  logic poll_en,
    output logic gap_done,
    output logic last_try
);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int TW = $clog2(POLL_MAX + 1);

    logic [GW-1:0] gap_cnt;
    logic [TW-1:0] try_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
            try_cnt <= '0;
        end else begin
            if (wait_en && !gap_done)
                gap_cnt <= gap_cnt + 1'b1;
            else
                gap_cnt <= '0;
            if (restart)
                try_cnt <= '0;
            else if (poll_en)
                try_cnt <= try_cnt + 1'b1;
        end
    end

    assign gap_done = wait_en && (gap_cnt == GW'(POLL_GAP - 1));
    assign last_try = (try_cnt == TW'(POLL_MAX - 1));
endmodule

// File: rtl/mbox_sender.sv
module mbox_sender
    import mbs_pkg::*;
#(
    parameter int AW       = 16,
    parameter int POLL_GAP = 4,
    parameter int POLL_MAX = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          link_up,
    input  logic [AW-1:0] mbox_base,
    input  logic [AW-1:0] mbox_size,
    input  logic          req_valid,
    input  logic [AW-1:0] req_len,
    output logic          busy,
    input  logic          wd_valid,
    output logic          wd_ready,
    input  logic [31:0]   wd_data,
    output logic          mem_we,
    output logic          mem_re,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_wdata,
    input  logic [31:0]   mem_rdata,
    output logic          doorbell,
    output logic          done,
    output logic [2:0]    status
);
    send_state_e   state;
    send_status_e  result_q;
    send_status_e  verdict;
    logic          accept;
    logic [AW-1:0] base_q;
    logic [AW-1:0] len_q;
    logic [AW-1:0] idx_q;
    logic [AW-1:0] nwords;
    logic          gap_done;
    logic          last_try;
    logic          hdr_match;
    logic          hdr_zero;

    mbs_req_check #(.AW(AW)) u_chk (
        .link_up (link_up),
        .len     (req_len),
        .size    (mbox_size),
        .accept  (accept),
        .verdict (verdict)
    );

    mbs_poll_timer #(.POLL_GAP(POLL_GAP), .POLL_MAX(POLL_MAX)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (state == S_RING),
        .wait_en  (state == S_GAP),
        .poll_en  (state == S_POLL),
        .gap_done (gap_done),
        .last_try (last_try)
    );

    assign nwords    = len_q >> 2;
    assign hdr_match = (mem_rdata == {{(DW-AW){1'b0}}, len_q});
    assign hdr_zero  = (mem_rdata == '0);

    // State register and captured request data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            result_q <= ST_OK;
            base_q   <= '0;
            len_q    <= '0;
            idx_q    <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (req_valid) begin
                    base_q   <= mbox_base;
                    len_q    <= req_len;
                    idx_q    <= '0;
                    result_q <= verdict;
                    if (!accept)
                        state <= S_DONE;
                    else if (req_len == '0)
                        state <= S_COMMIT;
                    else
                        state <= S_FILL;
                end
                S_FILL: if (wd_valid) begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == nwords - 1'b1)
                        state <= S_COMMIT;
                end
                S_COMMIT: state <= S_VERIFY;
                S_VERIFY: begin
                    if (hdr_match) begin
                        state <= S_RING;
                    end else begin
                        result_q <= ST_RBERR;
                        state    <= S_DONE;
                    end
                end
                S_RING: state <= S_GAP;
                S_GAP: if (gap_done) state <= S_POLL;
                S_POLL: begin
                    if (hdr_zero) begin
                        result_q <= ST_OK;
                        state    <= S_DONE;
                    end else if (last_try) begin
                        state <= S_CLEAR;
                    end else begin
                        state <= S_GAP;
                    end
                end
                S_CLEAR: begin
                    result_q <= ST_TIMEOUT;
                    state    <= S_DONE;
                end
                S_DONE: state <= S_IDLE;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Outputs decoded from state
    always_comb begin
        busy      = (state != S_IDLE);
        wd_ready  = 1'b0;
        mem_we    = 1'b0;
        mem_re    = 1'b0;
        mem_addr  = base_q;
        mem_wdata = '0;
        doorbell  = 1'b0;
        done      = 1'b0;
        status    = result_q;
        unique case (state)
            S_FILL: begin
                wd_ready  = 1'b1;
                mem_we    = wd_valid;
                mem_addr  = base_q + AW'(4) + (idx_q << 2);
                mem_wdata = wd_data;
            end
            S_COMMIT: begin
                mem_we    = 1'b1;
                mem_wdata = {{(DW-AW){1'b0}}, len_q};
            end
            S_VERIFY: mem_re   = 1'b1;
            S_RING:   doorbell = 1'b1;
            S_POLL:   mem_re   = 1'b1;
            S_CLEAR:  mem_we   = 1'b1;
            S_DONE:   done     = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mbox_sender_chk.sv
module mbox_sender_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       req_valid,
    input logic       wd_ready,
    input logic       mem_we,
    input logic       mem_re,
    input logic [31:0] mem_wdata,
    input logic       doorbell,
    input logic       done,
    input logic [2:0] status
);
    assert_doorbell_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell |=> !doorbell);

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_we && !mem_re && !doorbell && !wd_ready));

    assert_one_access_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re));

    assert_refuse_fast_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (status == 3'd1 || status == 3'd2)) |-> $past(req_valid && !busy));

    assert_rberr_after_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 3'd4) |-> $past(mem_re));

    assert_clear_before_timeout_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 3'd3) |-> $past(mem_we && mem_wdata == 32'd0));
endmodule

bind mbox_sender mbox_sender_chk u_chk_bind (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .req_valid (req_valid),
    .wd_ready  (wd_ready),
    .mem_we    (mem_we),
    .mem_re    (mem_re),
    .mem_wdata (mem_wdata),
    .doorbell  (doorbell),
    .done      (done),
    .status    (status)
);

// File: tb/sim_mbox_sender.sv
`timescale 1ns/1ps
module sim_mbox_sender;
    localparam int AW  = 16;
    localparam int GAP = 2;
    localparam int PM  = 6;
    localparam int WIN = (GAP + 1) * PM;   // cycles from doorbell to final poll

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic link_up = 1'b0;
    logic [AW-1:0] mbox_base = 16'h0020;
    logic [AW-1:0] mbox_size = 16'd16;
    logic req_valid = 1'b0;
    logic [AW-1:0] req_len = '0;
    logic busy, wd_ready, mem_we, mem_re, doorbell, done;
    logic wd_valid = 1'b0;
    logic [31:0] wd_data = '0;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata;
    logic [2:0] status;

    always #10 clk = ~clk;   // 50 MHz

    mbox_sender #(.AW(AW), .POLL_GAP(GAP), .POLL_MAX(PM)) u0 (
        .clk(clk), .rst_n(rst_n), .link_up(link_up), .mbox_base(mbox_base),
        .mbox_size(mbox_size), .req_valid(req_valid), .req_len(req_len),
        .busy(busy), .wd_valid(wd_valid), .wd_ready(wd_ready), .wd_data(wd_data),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .doorbell(doorbell),
        .done(done), .status(status)
    );

    // Shared memory model and remote responder
    logic [31:0] mem [64];
    logic drop_hdr = 1'b0;
    logic rem_on = 1'b0;
    int   rem_delay = 0;
    logic rem_arm = 1'b0;
    int   rem_cnt = 0;
    int   n_db = 0, n_we = 0, n_hdr_rd = 0, n_pay = 0, pay_snap = 0;
    int   total = 0, bad = 0, cyc = 0;

    assign mem_rdata = mem[mem_addr[7:2]];

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (mem_we) begin
            n_we <= n_we + 1;
            if (mem_addr == mbox_base) pay_snap <= n_pay;
            else n_pay <= n_pay + 1;
            if (!(drop_hdr && mem_addr == mbox_base)) mem[mem_addr[7:2]] <= mem_wdata;
        end
        if (mem_re && mem_addr == mbox_base) n_hdr_rd <= n_hdr_rd + 1;
        if (doorbell) begin
            n_db <= n_db + 1;
            if (rem_on) begin
                if (rem_delay == 0) mem[mbox_base[7:2]] <= 32'd0;
                else begin rem_arm <= 1'b1; rem_cnt <= rem_delay - 1; end
            end
        end else if (rem_arm) begin
            if (rem_cnt == 0) begin mem[mbox_base[7:2]] <= 32'd0; rem_arm <= 1'b0; end
            else rem_cnt <= rem_cnt - 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int len, input int k);
        return 32'hC3000000 ^ (32'(len) << 12) ^ (32'(k) * 32'h00010203);
    endfunction

    // One send; returns status observed with done
    task automatic send(input int len, input bit feed, output int st);
        int n;
        @(negedge clk);
        req_valid = 1'b1; req_len = AW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        if (feed) begin
            for (int k = 0; k < len / 4; k++) begin
                if (k == 1) begin wd_valid = 1'b0; @(negedge clk); end
                wd_valid = 1'b1; wd_data = pat(len, k);
                n = 0;
                while (!wd_ready && n < 50) begin @(negedge clk); n++; end
                @(negedge clk);
            end
            wd_valid = 1'b0;
        end
        n = 0;
        while (!done && n < 2000) begin @(negedge clk); n++; end
        st = done ? int'(status) : -1;
        @(negedge clk);
    endtask

    initial begin
        int st, db0, we0, rd0, pay0, exp_st;
        bit fit;
        for (int i = 0; i < 64; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done && !doorbell && !wd_ready && !mem_we && !mem_re, "R1", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: link down
        db0 = n_db; we0 = n_we;
        send(4, 1'b0, st);
        chk(st == 2, "R2 status", st, 2);
        chk(n_we == we0 && n_db == db0, "R2 no write", n_we - we0, 0);

        link_up = 1'b1;
        rem_on = 1'b1; rem_delay = 2;
        // R3/R4/R5/R6/R8: sweep of lengths for two mailbox sizes
        for (int sz = 16; sz <= 20; sz += 4) begin
            mbox_size = AW'(sz);
            for (int len = 0; len <= sz + 2; len++) begin
                fit = (len % 4 == 0) && (len + 4 <= sz);
                db0 = n_db; we0 = n_we; pay0 = n_pay;
                send(len, fit, st);
                exp_st = fit ? 0 : 1;
                chk(st == exp_st, fit ? "R8 status" : "R3 status", st, exp_st);
                if (fit) begin
                    for (int k = 0; k < len / 4; k++)
                        chk(mem[(32'(mbox_base) + 4 + 4 * k) >> 2] == pat(len, k), "R4 word", k, len);
                    chk(pay_snap - pay0 == len / 4, "R5 order", pay_snap - pay0, len / 4);
                    chk(n_db - db0 == 1, "R6 doorbell", n_db - db0, 1);
                end else begin
                    chk(n_we == we0 && n_db == db0, "R3 untouched", n_we - we0, 0);
                end
            end
        end
        mbox_size = 16'd16;

        // R7: header write lost, read-back mismatch
        mem[mbox_base[7:2]] = 32'hDEAD;
        drop_hdr = 1'b1; db0 = n_db;
        send(8, 1'b1, st);
        chk(st == 4, "R7 status", st, 4);
        chk(n_db == db0, "R7 no doorbell", n_db - db0, 0);
        drop_hdr = 1'b0;

        // R9/R10: remote silent; a request while busy must be ignored
        rem_on = 1'b0; db0 = n_db; rd0 = n_hdr_rd;
        fork
            send(12, 1'b1, st);
            begin
                repeat (12) @(negedge clk);
                req_valid = 1'b1; req_len = 16'd3;
                @(negedge clk);
                req_valid = 1'b0;
            end
        join
        chk(st == 3, "R9 status", st, 3);
        chk(mem[mbox_base[7:2]] == 32'd0, "R9 cleared", int'(mem[mbox_base[7:2]]), 0);
        chk(n_hdr_rd - rd0 == PM + 1, "R8 poll count", n_hdr_rd - rd0, PM + 1);
        chk(n_db - db0 == 1, "R6 single doorbell", n_db - db0, 1);
        we0 = 0;
        for (int i = 0; i < 20; i++) begin
            if (done || busy) we0++;
            @(negedge clk);
        end
        chk(we0 == 0, "R10 busy request ignored", we0, 0);

        // R11: remote clear around the final poll
        rem_on = 1'b1;
        for (int d = WIN - 4; d <= WIN + 2; d++) begin
            rem_delay = d; rd0 = n_hdr_rd;
            send(4, 1'b1, st);
            exp_st = (d <= WIN - 1) ? 0 : 3;
            chk(st == exp_st, "R11 race status", st, exp_st);
            if (exp_st == 3)
                chk(n_hdr_rd - rd0 == PM + 1, "R11 poll count", n_hdr_rd - rd0, PM + 1);
            repeat (WIN + 4) @(negedge clk);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule